// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It takes words from an external transmit FIFO, shifts them out most-significant bit first on the data output while toggling the serial clock, samples the serial data input, and pushes one received word into an external receive FIFO for every word sent. Words are 8, 16 or 32 bits long. The clock idle level, the clock edge on which output data changes, and the point at which input data is sampled are each selected by their own control input. The serial clock rate is the system clock divided by twice the baud value plus one.

The engine runs only when both its enable and its master-select controls are set. Clearing the enable stops the current word at once, parks the serial clock at its idle level and asserts a flush request to both FIFOs. When the next word is already waiting as the current one ends, the engine continues without an idle clock period. An optional hardware slave select stays active while the transmit FIFO holds data or a word is on the wire.

Top module: `spi_shift_engine`

## Requirements
- R1: The low W bits of each popped transmit word appear on `sdo` most-significant bit first, one bit per serial clock period, where W is the word size.
- R2: When no word is shifting, `sck` sits at the level of `ctl_idle_high` (1 means idle high, 0 means idle low).
- R3: With `ctl_late_edge` = 1, `sdo` changes when `sck` returns to its idle level and is valid at the leading (idle-to-active) edge; with `ctl_late_edge` = 0, `sdo` changes at the leading edge and is valid at the trailing edge.
- R4: With `ctl_late_sample` = 0, `sdi` is sampled at the clock edge half way through each bit; with 1, at the end of the bit. `rx_data` holds the W sampled bits, first-received bit in position W-1, upper bits zero.
- R5: `ctl_width` selects the word size: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 8; the size is taken when a word is loaded.
- R6: Each half of a serial clock period lasts `baud_div`+1 system clock cycles, so one `sck` period is 2×(`baud_div`+1) cycles.
- R7: With `ctl_auto_ss` = 1, `ss_n` is low while the engine is enabled in master operation and either `tx_valid` is high or a word is shifting; otherwise `ss_n` stays high, and with `ctl_auto_ss` = 0 it is always high.
- R8: A word is loaded only while `tx_valid` is high, with a one-cycle `tx_pop`; each completed word gives exactly one one-cycle `rx_push`.
- R9: No word is loaded and `busy` stays low unless both `ctl_enable` and `ctl_master` are set.
- R10: Clearing `ctl_enable` drops `busy` and returns `sck` to idle by the next cycle, discards the partial word with no `rx_push`, and holds `fifo_flush` high while the enable is clear.
- R11: When a word is waiting as the current one ends, the next word starts on the same cycle, so the `sck` period stays 2×(`baud_div`+1) across the word boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_enable | input | 1 | Engine enable; clearing it aborts and flushes |
| ctl_master | input | 1 | Master operation select; must be set to shift |
| ctl_idle_high | input | 1 | Serial clock idle level |
| ctl_late_edge | input | 1 | 1: output changes on active-to-idle edge; 0: on idle-to-active edge |
| ctl_late_sample | input | 1 | 1: sample at end of bit; 0: sample at mid bit |
| ctl_width | input | 2 | Word size code |
| ctl_auto_ss | input | 1 | Drive hardware slave select from FIFO occupancy |
| baud_div | input | 9 | Baud divisor value |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_data | input | 32 | Head word of the transmit FIFO |
| tx_pop | output | 1 | Pops the transmit FIFO head this cycle |
| rx_push | output | 1 | Pushes `rx_data` into the receive FIFO |
| rx_data | output | 32 | Received word, right aligned |
| fifo_flush | output | 1 | Flush request to both FIFOs |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |
| busy | output | 1 | A word is shifting |

## Verification
The assertions take for granted that `baud_div`, the polarity, edge, sample and width controls are held steady while a word is shifting, and that `tx_data` stays put while `tx_valid` is high and no pop occurs; the divisor hold is itself checked as an assumption property. The bench changes configuration only while reset is applied, loads each batch of words with the master select clear so a whole batch is queued before shifting begins, and then lets the batch run to completion or aborts it only through the enable input.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int MAX_W  = 32;
  localparam int BITS_W = $clog2(MAX_W) + 1;

  typedef enum logic { ENG_IDLE = 1'b0, ENG_SHIFT = 1'b1 } eng_state_e;
  typedef enum logic { HALF_FIRST = 1'b0, HALF_SECOND = 1'b1 } half_e;

  // Word size code to bit count; the unused code falls back to bytes.
  function automatic logic [BITS_W-1:0] word_bits(input logic [1:0] code);
    case (code)
      2'd1:    return BITS_W'(16);
      2'd2:    return BITS_W'(32);
      default: return BITS_W'(8);
    endcase
  endfunction

  // Moves the low 'bits' bits of a word to the top of the shifter.
  function automatic logic [MAX_W-1:0] align_msb(input logic [MAX_W-1:0] d,
                                                 input logic [BITS_W-1:0] bits);
    return d << (BITS_W'(MAX_W) - bits);
  endfunction

  // Keeps the low 'bits' bits; a 32-bit shift of all ones yields zero.
  function automatic logic [MAX_W-1:0] keep_low(input logic [MAX_W-1:0] d,
                                                input logic [BITS_W-1:0] bits);
    return d & ~({MAX_W{1'b1}} << bits);
  endfunction
endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud #(
  parameter int DIV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R6: a non-zero divisor never yields ticks on adjacent cycles
  p_tick_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0) |=> !tick_o)
    else $error("R6 baud ticks too close");

  // R6 input assumption: divisor held while a word is shifting
  p_div_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> $stable(div_i))
    else $error("R6 divisor changed mid word");
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
  import spi_eng_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             late_sample_i,
  input  logic [1:0]       width_code_i,
  input  logic             tx_valid_i,
  input  logic [MAX_W-1:0] tx_data_i,
  input  logic             sdi_i,
  output logic             tx_pop_o,
  output logic             busy_o,
  output logic             second_half_o,
  output logic             sdo_o,
  output logic             rx_push_o,
  output logic [MAX_W-1:0] rx_data_o
);
  eng_state_e        st_q;
  half_e             half_q;
  logic [BITS_W-1:0] bits_q, left_q;
  logic [MAX_W-1:0]  tx_sr_q, rx_sr_q;

  logic              last_tick, sample_now;
  logic [MAX_W-1:0]  rx_next;
  logic [BITS_W-1:0] load_bits;

  assign busy_o        = (st_q == ENG_SHIFT);
  assign second_half_o = (half_q == HALF_SECOND);
  assign sdo_o         = tx_sr_q[MAX_W-1];
  assign load_bits     = word_bits(width_code_i);

  assign last_tick  = busy_o && tick_i && second_half_o && (left_q == '0);
  assign tx_pop_o   = run_i && tx_valid_i && (!busy_o || last_tick);
  assign sample_now = busy_o && tick_i && (second_half_o == late_sample_i);
  assign rx_next    = sample_now ? {rx_sr_q[MAX_W-2:0], sdi_i} : rx_sr_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q      <= ENG_IDLE;
      half_q    <= HALF_FIRST;
      bits_q    <= BITS_W'(8);
      left_q    <= '0;
      tx_sr_q   <= '0;
      rx_sr_q   <= '0;
      rx_push_o <= 1'b0;
      rx_data_o <= '0;
    end else begin
      rx_push_o <= 1'b0;
      if (!run_i) begin
        st_q   <= ENG_IDLE;
        half_q <= HALF_FIRST;
      end else begin
        if (busy_o && tick_i) begin
          rx_sr_q <= rx_next;
          if (!second_half_o) begin
            half_q <= HALF_SECOND;
          end else begin
            half_q <= HALF_FIRST;
            if (left_q == '0) begin
              rx_push_o <= 1'b1;
              rx_data_o <= keep_low(rx_next, bits_q);
              if (!tx_valid_i) st_q <= ENG_IDLE;
            end else begin
              left_q  <= left_q - 1'b1;
              tx_sr_q <= tx_sr_q << 1;
            end
          end
        end
        if (tx_pop_o) begin
          st_q    <= ENG_SHIFT;
          half_q  <= HALF_FIRST;
          bits_q  <= load_bits;
          left_q  <= load_bits - 1'b1;
          tx_sr_q <= align_msb(tx_data_i, load_bits);
          rx_sr_q <= '0;
        end
      end
    end
  end

  // R8: every pop starts (or continues) a word
  p_pop_starts_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |=> busy_o)
    else $error("R8 pop without shifting");

  // R8: a received word only follows shifting
  p_push_after_shift_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> $past(busy_o))
    else $error("R8 push without a word");

  // R3: output bit changes only on a baud tick
  p_sdo_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> $stable(sdo_o))
    else $error("R3 sdo moved between ticks");

  // R6: each tick flips the half-period phase
  p_half_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && run_i && tick_i) |=> (half_q != $past(half_q)) || !busy_o)
    else $error("R6 half phase did not advance");
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_enable,
  input  logic             ctl_master,
  input  logic             ctl_idle_high,
  input  logic             ctl_late_edge,
  input  logic             ctl_late_sample,
  input  logic [1:0]       ctl_width,
  input  logic             ctl_auto_ss,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             tx_valid,
  input  logic [MAX_W-1:0] tx_data,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [MAX_W-1:0] rx_data,
  output logic             fifo_flush,
  output logic             sck,
  output logic             sdo,
  input  logic             sdi,
  output logic             ss_n,
  output logic             busy
);
  logic run, tick, second_half, clk_active;

  assign run        = ctl_enable && ctl_master;
  assign fifo_flush = !ctl_enable;

  spi_eng_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .run_i  (busy),
    .div_i  (baud_div),
    .tick_o (tick)
  );

  spi_eng_shifter u_shift (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .run_i         (run),
    .tick_i        (tick),
    .late_sample_i (ctl_late_sample),
    .width_code_i  (ctl_width),
    .tx_valid_i    (tx_valid),
    .tx_data_i     (tx_data),
    .sdi_i         (sdi),
    .tx_pop_o      (tx_pop),
    .busy_o        (busy),
    .second_half_o (second_half),
    .sdo_o         (sdo),
    .rx_push_o     (rx_push),
    .rx_data_o     (rx_data)
  );

  // Late edge: first half idle, second half active; otherwise the reverse.
  assign clk_active = busy && (second_half ? ctl_late_edge : !ctl_late_edge);
  assign sck        = ctl_idle_high ^ clk_active;
  assign ss_n       = !(ctl_auto_ss && run && (tx_valid || busy));

  // R10: clearing the enable stops the engine and parks the clock
  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> (!busy && sck == ctl_idle_high))
    else $error("R10 engine still running after disable");

  // R9: nothing is popped without both enable and master
  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_master |=> !busy)
    else $error("R9 shifting without master select");
endmodule

// File: tb/spi_shift_engine_test.sv
module spi_shift_engine_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, ctl_enable, ctl_master, ctl_idle_high, ctl_late_edge;
  logic        ctl_late_sample, ctl_auto_ss;
  logic [1:0]  ctl_width;
  logic [8:0]  baud_div;
  logic        tx_pop, rx_push, fifo_flush, sck, sdo, ss_n, busy;
  logic [31:0] rx_data;
  logic        sdi;

  logic [31:0] fq [0:63];
  int          wp = 0, rp = 0;
  wire         tx_valid = (wp != rp);
  wire [31:0]  tx_data  = fq[rp % 64];

  spi_shift_engine uut (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_master(ctl_master),
    .ctl_idle_high(ctl_idle_high), .ctl_late_edge(ctl_late_edge),
    .ctl_late_sample(ctl_late_sample), .ctl_width(ctl_width),
    .ctl_auto_ss(ctl_auto_ss), .baud_div(baud_div), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .fifo_flush(fifo_flush), .sck(sck), .sdo(sdo), .sdi(sdi), .ss_n(ss_n),
    .busy(busy)
  );

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  int W = 8;
  bit sl_en = 0, sdi_mode = 0;
  int pres = 0, capn = 0, n_push = 0, ss_bad = 0, ss_low = 0;
  int lead_last = -1, gap_min = 1000000, gap_max = 0;
  logic [31:0] cap = '0;
  logic [31:0] exp_sdo[$];
  logic [31:0] exp_rx[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] wmask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic logic [31:0] reply(input int k);
    return (32'h9E37_79B9 * 32'(k + 1)) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic stream_bit(input int p, input int w);
    logic [31:0] r;
    r = reply(p / w);
    return r[w - 1 - (p % w)];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (fifo_flush) rp <= wp;
    else if (tx_pop) rp <= rp + 1;
  end

  // Slave model: drives sdi per the chosen output edge, or a half-marker pattern.
  always @* begin
    if (sdi_mode)           sdi = (sck ^ ctl_idle_high) ^ ctl_late_edge;
    else if (ctl_late_edge) sdi = stream_bit(pres, W);
    else                    sdi = (pres > 0) ? stream_bit(pres - 1, W) : 1'b0;
  end

  task automatic capture_bit();
    logic [31:0] e;
    cap = {cap[30:0], sdo};
    capn++;
    if (capn == W) begin
      if (exp_sdo.size() == 0) check(1'b0, "R1 unexpected word on sdo", cap, 32'h0);
      else begin
        e = exp_sdo.pop_front();
        check((cap & wmask(W)) == e, "R1/R3 sdo word", cap & wmask(W), e);
      end
      capn = 0;
      cap  = '0;
    end
  endtask

  always @(sck) begin
    if (sl_en) begin
      if (sck != ctl_idle_high) begin
        if (lead_last >= 0) begin
          if (cyc - lead_last < gap_min) gap_min = cyc - lead_last;
          if (cyc - lead_last > gap_max) gap_max = cyc - lead_last;
        end
        lead_last = cyc;
        if (ctl_late_edge) capture_bit(); else pres++;
      end else begin
        if (ctl_late_edge) pres++; else capture_bit();
      end
    end
  end

  always @(negedge clk) begin
    logic [31:0] e;
    if (rst_n && rx_push) begin
      n_push++;
      if (exp_rx.size() == 0) check(1'b0, "R8 unexpected rx_push", rx_data, 32'h0);
      else begin
        e = exp_rx.pop_front();
        check(rx_data == e, "R4 received word", rx_data, e);
      end
    end
    if (rst_n && sl_en) begin
      if (ctl_auto_ss && busy && ss_n) ss_bad++;
      if (!ctl_auto_ss && !ss_n) ss_bad++;
      if (!ss_n) ss_low++;
    end
  end

  task automatic setup(input bit ih, input bit le, input bit ls, input logic [1:0] wc,
                       input int bd, input bit as, input bit sm);
    rst_n = 0; sl_en = 0; ctl_enable = 0; ctl_master = 0;
    ctl_idle_high = ih; ctl_late_edge = le; ctl_late_sample = ls;
    ctl_width = wc; baud_div = 9'(bd); ctl_auto_ss = as; sdi_mode = sm;
    W = (wc == 2'd1) ? 16 : ((wc == 2'd2) ? 32 : 8);   // R5 size decode
    pres = 0; capn = 0; cap = '0; n_push = 0; ss_bad = 0; ss_low = 0;
    lead_last = -1; gap_min = 1000000; gap_max = 0;
    exp_sdo.delete(); exp_rx.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ctl_enable = 1;
    @(negedge clk);
    sl_en = 1;
  endtask

  task automatic load_words(input int n, input logic [31:0] seed, input bit sm, input bit ls);
    logic [31:0] v;
    for (int k = 0; k < n; k++) begin
      v = seed ^ (32'h1234_5679 * 32'(k + 1));
      fq[wp % 64] = v;
      wp++;
      exp_sdo.push_back(v & wmask(W));
      if (sm) exp_rx.push_back(ls ? 32'h0 : wmask(W));
      else    exp_rx.push_back(reply(k) & wmask(W));
    end
  endtask

  task automatic run_case(input bit ih, input bit le, input bit ls, input logic [1:0] wc,
                          input int bd, input bit as, input int n, input bit sm,
                          input logic [31:0] seed);
    int lim;
    setup(ih, le, ls, wc, bd, as, sm);
    load_words(n, seed, sm, ls);
    repeat (6) @(negedge clk);
    check(busy == 0 && n_push == 0, "R9 master clear holds engine", {31'b0, busy}, 32'h0);
    check(sck == ih, "R2 idle level before start", {31'b0, sck}, {31'b0, ih});
    ctl_master = 1;
    lim = 0;
    while ((exp_rx.size() != 0 || busy) && lim < 20000) begin
      @(negedge clk);
      lim++;
    end
    check(n_push == n, "R8 one push per word", 32'(n_push), 32'(n));
    check(exp_sdo.size() == 0, "R1 all words seen on sdo", 32'(exp_sdo.size()), 32'h0);
    check(gap_min == 2 * (bd + 1) && gap_max == 2 * (bd + 1),
          "R6/R11 sck period incl. word boundaries", 32'(gap_max), 32'(2 * (bd + 1)));
    check(sck == ih, "R2 idle level after words", {31'b0, sck}, {31'b0, ih});
    check(ss_bad == 0, "R7 slave select tracking", 32'(ss_bad), 32'h0);
    if (as) check(ss_low > 0, "R7 slave select asserted", 32'(ss_low), 32'h1);
    check(ss_n == 1'b1, "R7 slave select released", {31'b0, ss_n}, 32'h1);
    sl_en = 0;
  endtask

  task automatic abort_case();
    setup(1'b0, 1'b1, 1'b0, 2'd1, 3, 1'b1, 1'b0);
    load_words(2, 32'hBEEF_0123, 1'b0, 1'b0);
    ctl_master = 1;
    repeat (20) @(negedge clk);
    check(busy == 1'b1, "R10 word in flight before abort", {31'b0, busy}, 32'h1);
    ctl_enable = 0;
    sl_en = 0;
    @(negedge clk);
    check(busy == 1'b0, "R10 busy drops", {31'b0, busy}, 32'h0);
    check(sck == 1'b0, "R10 sck parked idle", {31'b0, sck}, 32'h0);
    check(fifo_flush == 1'b1, "R10 flush asserted", {31'b0, fifo_flush}, 32'h1);
    check(tx_valid == 1'b0, "R10 transmit FIFO emptied", {31'b0, tx_valid}, 32'h0);
    exp_rx.delete(); exp_sdo.delete();
    repeat (150) @(negedge clk);
    check(n_push == 0, "R10 no push for aborted word", 32'(n_push), 32'h0);
  endtask

  initial begin
    rst_n = 0; ctl_enable = 0; ctl_master = 0; ctl_idle_high = 0; ctl_late_edge = 0;
    ctl_late_sample = 0; ctl_width = 0; ctl_auto_ss = 0; baud_div = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(sck == 1'b0, "R2 reset sck idle", {31'b0, sck}, 32'h0);
    check(busy == 1'b0 && tx_pop == 1'b0 && rx_push == 1'b0, "R9 reset quiet",
          {29'b0, busy, tx_pop, rx_push}, 32'h0);
    check(ss_n == 1'b1, "R7 reset slave select", {31'b0, ss_n}, 32'h1);
    check(fifo_flush == 1'b1, "R10 flush while disabled", {31'b0, fifo_flush}, 32'h1);

    run_case(1'b0, 1'b1, 1'b0, 2'd0, 0, 1'b1, 3, 1'b0, 32'hA5C3_1E7B); // R1 R3 R11
    run_case(1'b1, 1'b0, 1'b1, 2'd1, 2, 1'b1, 2, 1'b0, 32'h0F1E_2D3C); // R2 R3
    run_case(1'b0, 1'b0, 1'b0, 2'd2, 1, 1'b0, 2, 1'b0, 32'h7654_3210); // R5 32-bit, R7 manual
    run_case(1'b1, 1'b1, 1'b1, 2'd3, 4, 1'b1, 2, 1'b0, 32'hC0DE_F00D); // R5 code 3
    run_case(1'b0, 1'b1, 1'b0, 2'd0, 3, 1'b1, 1, 1'b1, 32'h0000_0081); // R4 mid
    run_case(1'b0, 1'b1, 1'b1, 2'd0, 3, 1'b1, 1, 1'b1, 32'h0000_0042); // R4 end
    run_case(1'b1, 1'b0, 1'b0, 2'd0, 2, 1'b1, 1, 1'b1, 32'h0000_00E7); // R4 mid
    run_case(1'b1, 1'b0, 1'b1, 2'd0, 2, 1'b1, 1, 1'b1, 32'h0000_0018); // R4 end
    abort_case();

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule